// File: doc/BRIEF.md
# Segmented Speculative-Carry Adder

This block adds two unsigned N-bit operands and a carry-in, producing an N-bit sum and a carry-out, purely in combinational logic. The operand width is cut into equal slices of K bits. The bottom slice is one plain ripple chain that takes the external carry-in. Each slice above it holds two ripple chains. One works out its result as if no carry arrived and the other as if a carry arrived. The real carry leaving the slice below then steers a 2:1 selector that keeps one of the two results.

The delay of a slice stays at K full-add stages whatever N is. Between slices only one selector stage is added, so a long ripple through all N bits is avoided. The block is meant to sit inside a datapath that registers both its inputs and its outputs. It has no clock of its own.

Top module: `csa_adder_top`

## Requirements
- R1: For every input, {cout, sum} equals the (N+1)-bit value a + b + cin.
- R2: With a all ones, b zero and cin = 1, the carry passes through every slice: sum is 0 and cout is 1.
- R3: The bottom slice takes cin directly. With a = b = 0 and cin = 1, sum is 1 and cout is 0.
- R4: The carry out of bit K-1, the top of the bottom slice, selects the carry-assumed copy of the next slice. With a = 2^K - 1, b = 1 and cin = 0, sum is 2^K.
- R5: cout is the selected carry of the top slice. With a = b = 2^(N-1) and cin = 0, sum is 0 and cout is 1.
- R6: When no slice produces a carry, no carry copy is picked. With a = 0x55…5, b = 0xAA…A and cin = 0, sum is all ones and cout is 0.
- R7: The outputs are combinational. A new input is reflected at the ports within the same clock period, with no register in between.
- R8: N must be a whole multiple of K. Any other pairing stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | first operand |
| b | input | N | second operand |
| cin | input | 1 | carry into bit 0 |
| sum | output | N | low N bits of the total |
| cout | output | 1 | carry out of bit N-1 |

## Verification
Suppose a speculative copy computes the wrong value, or a selector is steered by the wrong carry. Then the sum shows an error of exactly 2^(jK) at the base of the affected slice j, and often a wrong cout as well. The error is visible in the same period the operands are applied. Long carry chains expose a broken link between slices, because they force every selector onto its carry-assumed copy: all-ones plus carry-in, and a carry out of the bottom slice. Patterns without carries expose the opposite fault, a selector stuck on its carry-assumed copy.

// File: rtl/csa_pkg.sv
package csa_pkg;
  localparam int unsigned CSA_DEF_WIDTH = 32;
  localparam int unsigned CSA_DEF_SEG   = 4;

  typedef struct packed {
    logic carry;
    logic sel;
  } csa_link_t;

  function automatic int unsigned csa_seg_count(input int unsigned width,
                                                input int unsigned seg);
    return width / seg;
  endfunction
endpackage

// File: rtl/csa_ripple_seg.sv
module csa_ripple_seg #(
  parameter int unsigned K = 4
) (
  input  logic [K-1:0] x,
  input  logic [K-1:0] y,
  input  logic         ci,
  output logic [K-1:0] s,
  output logic         co
);
  logic [K:0] chain;

  assign chain[0] = ci;

  for (genvar i = 0; i < K; i++) begin : g_bit
    assign s[i]       = x[i] ^ y[i] ^ chain[i];
    assign chain[i+1] = (x[i] & y[i]) | (x[i] & chain[i]) | (y[i] & chain[i]);
  end

  assign co = chain[K];

  always_comb begin
    AST_RIPPLE_SUM: assert ({co, s} == ({1'b0, x} + {1'b0, y} + {{K{1'b0}}, ci})); // R1
  end
endmodule

// File: rtl/csa_select_seg.sv
module csa_select_seg #(
  parameter int unsigned K = 4
) (
  input  logic [K-1:0] x,
  input  logic [K-1:0] y,
  input  logic         sel,
  output logic [K-1:0] s,
  output logic         co
);
  logic [K-1:0] s_nc, s_wc;
  logic         co_nc, co_wc;

  csa_ripple_seg #(.K(K)) u_no_carry (
    .x(x), .y(y), .ci(1'b0), .s(s_nc), .co(co_nc)
  );

  csa_ripple_seg #(.K(K)) u_with_carry (
    .x(x), .y(y), .ci(1'b1), .s(s_wc), .co(co_wc)
  );

  always_comb begin
    if (sel) begin
      s  = s_wc;
      co = co_wc;
    end else begin
      s  = s_nc;
      co = co_nc;
    end
  end

  always_comb begin
    AST_COPY_GAP: assert ({co_wc, s_wc} == ({co_nc, s_nc} + 1'b1)); // R4
    AST_NC_CARRY_IMPLIES_WC: assert (!co_nc || co_wc); // R6
  end
endmodule

// File: rtl/csa_adder_top.sv
module csa_adder_top
  import csa_pkg::*;
#(
  parameter int unsigned N = CSA_DEF_WIDTH,
  parameter int unsigned K = CSA_DEF_SEG
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);
  localparam int unsigned SEGS = csa_seg_count(N, K);

  if ((N % K) != 0 || K == 0) begin : g_bad_split
    $error("csa_adder_top: width must be a whole multiple of the slice size"); // R8
  end

  logic [SEGS:0] seg_c;

  assign seg_c[0] = cin;

  for (genvar j = 0; j < SEGS; j++) begin : g_seg
    if (j == 0) begin : g_base
      csa_ripple_seg #(.K(K)) u_base (
        .x(a[K-1:0]), .y(b[K-1:0]), .ci(seg_c[0]),
        .s(sum[K-1:0]), .co(seg_c[1])
      );
    end else begin : g_spec
      csa_select_seg #(.K(K)) u_spec (
        .x(a[j*K +: K]), .y(b[j*K +: K]), .sel(seg_c[j]),
        .s(sum[j*K +: K]), .co(seg_c[j+1])
      );
    end
  end

  assign cout = seg_c[SEGS];

  always_comb begin
    AST_BASE_TAKES_CIN: assert (!((a[K-1:0] == '0) && (b[K-1:0] == '0)) || (sum[0] == cin)); // R3
    AST_FULL_CHAIN: assert (!((&(a ^ b)) && cin) || ((sum == '0) && cout)); // R2
    AST_TOP_CARRY: assert (!(a[N-1] && b[N-1]) || cout); // R5
  end
endmodule

// File: tb/csa_adder_top_tb_top.sv
`timescale 1ns/1ps
module csa_adder_top_tb_top;
  localparam int unsigned N = 32;
  localparam int unsigned K = 4;

  logic clk;
  logic rst_n;
  logic [N-1:0] a, b, sum;
  logic cin, cout;

  int checks;
  int failures;
  bit done;

  logic [N:0] exp_q[$];
  string      tag_q[$];

  csa_adder_top #(.N(N), .K(K)) dut_i (
    .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic drive(input logic [N-1:0] va, input logic [N-1:0] vb,
                       input logic vc, input string tag);
    @(posedge clk);
    a   <= va;
    b   <= vb;
    cin <= vc;
    exp_q.push_back({1'b0, va} + {1'b0, vb} + {{N{1'b0}}, vc});
    tag_q.push_back(tag);
  endtask

  // monitor: pops expected values half a period after each drive (R7: same period)
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      logic [N:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({cout, sum} !== e) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", t, {cout, sum}, e);
      end
    end
  end

  initial begin
    checks = 0; failures = 0; done = 0;
    a = '0; b = '0; cin = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if ({cout, sum} !== '0) begin
      failures++;
      $display("FAIL R1 idle actual=%h expected=0", {cout, sum});
    end
    drive('0, '0, 1'b1, "R3");
    drive('1, '0, 1'b1, "R2");
    drive('0, '1, 1'b1, "R2");
    drive({{(N-K){1'b0}}, {K{1'b1}}}, {{(N-1){1'b0}}, 1'b1}, 1'b0, "R4");
    drive({1'b1, {(N-1){1'b0}}}, {1'b1, {(N-1){1'b0}}}, 1'b0, "R5");
    drive({(N/2){2'b01}}, {(N/2){2'b10}}, 1'b0, "R6");
    drive({(N/2){2'b01}}, {(N/2){2'b10}}, 1'b1, "R2");
    drive('1, '1, 1'b1, "R1");
    drive('1, '1, 1'b0, "R1");
    for (int j = 1; j < N / K; j++) begin
      drive({N{1'b0}} | (({K{1'b1}}) << (j*K)), {N{1'b0}} | (1 << (j*K)), 1'b0, "R4");
    end
    for (int i = 0; i < 300; i++) begin
      drive($urandom, $urandom, 1'($urandom), "R1");
    end
    drive('0, '0, 1'b0, "R7");
    drive('1, '0, 1'b0, "R7");
    repeat (3) @(posedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule